// File: doc/BRIEF.md
# Synchronizing SCL Clock Generator

This block produces the serial clock of a two-wire bus master from a reloadable half-period counter. The counter advances only on a count-source enable. The pin is open-drain: the block either pulls SCL low or leaves it high-impedance. It reads the line back through a synchronizer. When synchronization is on, another master pulling the line low cuts the internal high phase short. A device holding the line low stretches the clock, because the internal high phase does not count until the line is seen high.

A transfer starts with a one-cycle start pulse. It opens with an internal high half-period. Nine clock pulses follow, or ten when the extra-pulse phase option is set. At the falling edge that ends the last pulse, the clock either parks low or returns the line to idle, as the hold controls select. A force-low control and a release-on-stop control act on the pin independently of the sequence. Generating start and stop conditions, and moving data, are done elsewhere.

Top module: `scl_sync_gen`

## Requirements
- R1: After reset, `sclDriveLow` is 0 (1 = pull the line low, 0 = high-impedance), `xferClk` is 0 and `bitCnt` is 0.
- R2: A start pulse while idle begins a transfer with the internal clock high. Each internal half-period lasts `reloadVal`+1 cycles in which `tickEn` is 1. When synchronization is active, the high half-periods count only once the sensed line reads high. With two synchronizer stages this makes an undisturbed high phase `reloadVal`+3 cycles with `tickEn` held at 1. With synchronization active, `reloadVal` must be at least 2.
- R3: `bitCnt` increments on each low-to-high step of the internal clock and stops at 9 (`phaseOpt`=0) or 10 (`phaseOpt`=1). It keeps that value until the next transfer starts. A start pulse during a transfer is ignored.
- R4: At the falling edge after the last pulse, the line stays pulled low if the selected hold bit is 1 and is released otherwise. The selected hold bit is `hold9En` when `phaseOpt`=0 and `hold10En` when `phaseOpt`=1; the other bit has no effect.
- R5: While parked low, clearing the selected hold bit releases the line one cycle later.
- R6: With synchronization active, a falling line seen while the internal clock is high drives the internal clock low at once and reloads the counter, so the new low phase lasts a full `reloadVal`+1 ticks.
- R7: With synchronization active, while the internal clock is high and the line reads low, the counter is frozen and the internal clock stays high. Counting resumes once the line reads high.
- R8: Synchronization is active only when both `syncEn` and `intClkSel` are 1. Otherwise, the line level has no effect on the internal timing.
- R9: `xferClk` is the AND of the internal clock and the synchronized line level during a transfer, and is 0 outside one.
- R10: While `forceLow` is 1, `sclDriveLow` is 1, even mid-transfer. After `forceLow` clears, the transfer goes on normally.
- R11: A `stopSeen` pulse with `relOnStop`=1 ends any transfer or hold and releases the line on the next cycle. With `relOnStop`=0, `stopSeen` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count-source enable for the half-period counter |
| reloadVal | input | CNT_W | Half-period reload value |
| sclPin | input | 1 | Sensed SCL line level |
| goStart | input | 1 | One-cycle pulse that starts a transfer |
| syncEn | input | 1 | Enable clock synchronization with the line |
| intClkSel | input | 1 | 1 = internal clock source selected |
| hold9En | input | 1 | Park low after the 9th pulse (phaseOpt=0) |
| phaseOpt | input | 1 | Add a 10th pulse to the sequence |
| hold10En | input | 1 | Park low after the 10th pulse (phaseOpt=1) |
| forceLow | input | 1 | Force the line low |
| relOnStop | input | 1 | Release the line when a stop condition is seen |
| stopSeen | input | 1 | Stop condition detected |
| sclDriveLow | output | 1 | 1 = pull SCL low, 0 = high-impedance |
| xferClk | output | 1 | Effective transfer clock |
| bitCnt | output | 4 | Count of internal clock pulses in this transfer |

## Verification
The bench models the open-drain line as a wired AND of the block's drive and an external puller. It then checks the corner cases one at a time:
- **Stretch:** the external puller holds the line low through a high phase. A design that kept counting would run through the remaining bits unseen.
- **Early fall:** a short low pulse lands in the middle of a long high phase. A design that skipped the reload would end the new low phase early.
- **Synchronizer echo:** the block's own low phases reach the synchronized level late, so the high phases come out two cycles longer. A design that counted from the stale level would produce short highs.
- **Controls:** the bench also checks hold selection under each phase option, force-low mid-transfer, stop release against an ignored stop, and a restart attempt during a transfer. A wrong end count, a stuck or missing hold, or a bit counter cleared in mid-flight shows up at the ports.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int BIT_W = 4;
  localparam logic [BIT_W-1:0] LAST_BIT_BASE = 4'd9;
  localparam logic [BIT_W-1:0] LAST_BIT_EXT  = 4'd10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sclState_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic reload;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/scl_dpath.sv
module scl_dpath
  import scl_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclPin,
  input  logic [CNT_W-1:0] reloadVal,
  input  cntStrobe_t       strobe,
  output logic             sclS,
  output logic             sclFall,
  output logic             cntZero
);
  localparam int TOP_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sclPrev;
  logic [CNT_W-1:0]       cnt;

  // line synchronizer, idle-high after reset
  generate
    if (SYNC_STAGES > 1) begin : gChain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '1;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], sclPin};
      end
    end else begin : gSingle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '1;
        else        syncChain <= sclPin;
      end
    end
  endgenerate

  assign sclS = syncChain[TOP_STAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclPrev <= 1'b1;
    else        sclPrev <= sclS;
  end

  assign sclFall = sclPrev & ~sclS;

  // half-period counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (strobe.reload) cnt <= reloadVal;
    else if (strobe.dec)    cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             goStart,
  input  logic             syncEn,
  input  logic             intClkSel,
  input  logic             hold9En,
  input  logic             phaseOpt,
  input  logic             hold10En,
  input  logic             relOnStop,
  input  logic             stopSeen,
  input  logic             sclS,
  input  logic             sclFall,
  input  logic             cntZero,
  output cntStrobe_t       strobe,
  output sclState_t        state,
  output logic             intClk,
  output logic [BIT_W-1:0] bitCnt
);
  logic             syncOn;
  logic             running;
  logic             frozen;
  logic             syncCut;
  logic             expire;
  logic             stepDn;
  logic             fallNow;
  logic             riseNow;
  logic             holdSel;
  logic             stopHit;
  logic             atLast;
  logic [BIT_W-1:0] lastBit;

  assign syncOn  = syncEn & intClkSel;
  assign running = (state == ST_RUN);
  assign lastBit = phaseOpt ? LAST_BIT_EXT : LAST_BIT_BASE;
  assign holdSel = phaseOpt ? hold10En : hold9En;
  assign stopHit = stopSeen & relOnStop;
  assign atLast  = (bitCnt == lastBit);

  // line held low while internal clock is high: stall
  assign frozen  = syncOn & intClk & ~sclS;
  assign syncCut = running & syncOn & intClk & sclFall;
  assign expire  = running & tickEn & ~frozen & cntZero;
  assign stepDn  = running & tickEn & ~frozen & ~cntZero;
  assign fallNow = syncCut | (expire & intClk);
  assign riseNow = expire & ~intClk & ~syncCut;

  always_comb begin
    strobe        = '0;
    strobe.reload = ((state == ST_IDLE) & goStart) | fallNow | riseNow;
    strobe.dec    = stepDn & ~syncCut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      intClk <= 1'b1;
      bitCnt <= '0;
    end else if (stopHit) begin
      state  <= ST_IDLE;
      intClk <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (goStart) begin
            state  <= ST_RUN;
            intClk <= 1'b1;
            bitCnt <= '0;
          end
        end
        ST_RUN: begin
          if (fallNow) begin
            if (atLast) begin
              state  <= holdSel ? ST_HOLD : ST_IDLE;
              intClk <= ~holdSel;
            end else begin
              intClk <= 1'b0;
            end
          end else if (riseNow) begin
            intClk <= 1'b1;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!holdSel) begin
            state  <= ST_IDLE;
            intClk <= 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          intClk <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             sclPin,
  input  logic             goStart,
  input  logic             syncEn,
  input  logic             intClkSel,
  input  logic             hold9En,
  input  logic             phaseOpt,
  input  logic             hold10En,
  input  logic             forceLow,
  input  logic             relOnStop,
  input  logic             stopSeen,
  output logic             sclDriveLow,
  output logic             xferClk,
  output logic [BIT_W-1:0] bitCnt
);
  cntStrobe_t strobe;
  sclState_t  state;
  logic       sclS;
  logic       sclFall;
  logic       cntZero;
  logic       intClk;
  logic       running;
  logic       parked;

  scl_dpath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclPin   (sclPin),
    .reloadVal(reloadVal),
    .strobe   (strobe),
    .sclS     (sclS),
    .sclFall  (sclFall),
    .cntZero  (cntZero)
  );

  scl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .goStart  (goStart),
    .syncEn   (syncEn),
    .intClkSel(intClkSel),
    .hold9En  (hold9En),
    .phaseOpt (phaseOpt),
    .hold10En (hold10En),
    .relOnStop(relOnStop),
    .stopSeen (stopSeen),
    .sclS     (sclS),
    .sclFall  (sclFall),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .state    (state),
    .intClk   (intClk),
    .bitCnt   (bitCnt)
  );

  assign running     = (state == ST_RUN);
  assign parked      = (state == ST_HOLD);
  assign sclDriveLow = forceLow | parked | (running & ~intClk);
  assign xferClk     = running & intClk & sclS;
endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       forceLow,
  input logic       stopSeen,
  input logic       relOnStop,
  input logic       syncEn,
  input logic       intClkSel,
  input logic       sclDriveLow,
  input logic       xferClk,
  input logic [3:0] bitCnt,
  input logic       intClk,
  input logic       running,
  input logic       sclS,
  input logic       sclFall
);
  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    forceLow |-> sclDriveLow); // R10

  AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (stopSeen && relOnStop) |=> (sclDriveLow == forceLow)); // R11

  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && intClk && syncEn && intClkSel && !sclS && !sclFall && !(stopSeen && relOnStop))
      |=> intClk); // R7

  AST_SYNC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (running && intClk && syncEn && intClkSel && sclFall && !(stopSeen && relOnStop))
      |=> (sclDriveLow || !running)); // R6

  AST_XCLK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    xferClk |-> (!sclDriveLow || forceLow)); // R9

  AST_BITCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCnt != $past(bitCnt)) |-> ((bitCnt == $past(bitCnt) + 4'd1) || (bitCnt == 4'd0))); // R3

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= 4'd10); // R3
endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .forceLow   (forceLow),
  .stopSeen   (stopSeen),
  .relOnStop  (relOnStop),
  .syncEn     (syncEn),
  .intClkSel  (intClkSel),
  .sclDriveLow(sclDriveLow),
  .xferClk    (xferClk),
  .bitCnt     (bitCnt),
  .intClk     (intClk),
  .running    (running),
  .sclS       (sclS),
  .sclFall    (sclFall)
);

// File: tb/scl_sync_gen_tb.sv
`timescale 1ns/1ps
module scl_sync_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reloadVal = 8'd3;
  logic       goStart = 1'b0, syncEn = 1'b0, intClkSel = 1'b1;
  logic       hold9En = 1'b0, phaseOpt = 1'b0, hold10En = 1'b0;
  logic       forceLow = 1'b0, relOnStop = 1'b0, stopSeen = 1'b0;
  logic       extLow = 1'b0, useDiv2 = 1'b0, tickPh = 1'b0;
  logic       tickEn, sclPin, sclDriveLow, xferClk;
  logic [3:0] bitCnt;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tickPh <= ~tickPh;
  assign tickEn = useDiv2 ? tickPh : 1'b1;
  assign sclPin = ~(sclDriveLow | extLow);  // wired-AND line

  scl_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .reloadVal(reloadVal), .sclPin(sclPin),
    .goStart(goStart), .syncEn(syncEn), .intClkSel(intClkSel), .hold9En(hold9En),
    .phaseOpt(phaseOpt), .hold10En(hold10En), .forceLow(forceLow), .relOnStop(relOnStop),
    .stopSeen(stopSeen), .sclDriveLow(sclDriveLow), .xferClk(xferClk), .bitCnt(bitCnt)
  );

  typedef struct packed {
    logic [7:0] rl; logic sync; logic ph; logic h9; logic h10; logic div2;
    logic [3:0] eBits; logic eHold; logic [7:0] eLow; logic [7:0] eHigh;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9,  1'b0, 8'd4, 8'd4},
    '{8'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9,  1'b1, 8'd4, 8'd6},
    '{8'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10, 1'b1, 8'd6, 8'd6},
    '{8'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10, 1'b0, 8'd3, 8'd5},
    '{8'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9,  1'b0, 8'd3, 8'd3},
    '{8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9,  1'b1, 8'd8, 8'd8}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; goStart = 0; syncEn = 0; intClkSel = 1; hold9En = 0; phaseOpt = 0;
    hold10En = 0; forceLow = 0; relOnStop = 0; stopSeen = 0; extLow = 0; useDiv2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseGo();
    goStart = 1'b1;
    @(negedge clk);
    goStart = 1'b0;
  endtask

  task automatic waitLowAt(int b);
    for (int i = 0; i < 400; i++) begin
      if (bitCnt == 4'(b) && sclDriveLow) break;
      @(negedge clk);
    end
  endtask

  task automatic runVec(int idx);
    vec_t v = VECS[idx];
    int lows = 0, curLow = 0, curHigh = 0, firstLow = -1, firstHigh = -1;
    int win;
    logic prevD = 1'b0;
    doReset();
    reloadVal = v.rl; syncEn = v.sync; phaseOpt = v.ph; hold9En = v.h9;
    hold10En = v.h10; useDiv2 = v.div2;
    win = 24 * (int'(v.rl) + 3) * (v.div2 ? 2 : 1) + 20;
    pulseGo();
    for (int c = 0; c < win; c++) begin
      if (sclDriveLow) begin
        if (!prevD && lows == 1 && firstHigh < 0) firstHigh = curHigh;
        curLow++;
      end else begin
        if (prevD) begin
          lows++;
          if (firstLow < 0) firstLow = curLow;
          curLow = 0; curHigh = 0;
        end
        curHigh++;
      end
      prevD = sclDriveLow;
      @(negedge clk);
    end
    chk($sformatf("R2 low half vec%0d", idx), firstLow, int'(v.eLow));
    chk($sformatf("R2 high half vec%0d", idx), firstHigh, int'(v.eHigh));
    chk($sformatf("R3 pulses vec%0d", idx), lows, int'(v.eBits));
    chk($sformatf("R3 bitCnt vec%0d", idx), int'(bitCnt), int'(v.eBits));
    chk($sformatf("R4 end drive vec%0d", idx), int'(sclDriveLow), int'(v.eHold));
    chk($sformatf("R9 xferClk idle vec%0d", idx), int'(xferClk), 0);
    if (v.eHold) begin
      hold9En = 1'b0; hold10En = 1'b0;
      @(negedge clk);
      chk($sformatf("R5 hold release vec%0d", idx), int'(sclDriveLow), 0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R1 reset state
    doReset();
    chk("R1 drive", int'(sclDriveLow), 0);
    chk("R1 xferClk", int'(xferClk), 0);
    chk("R1 bitCnt", int'(bitCnt), 0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R7 / R9: stretch during a high phase
    doReset();
    reloadVal = 8'd3; syncEn = 1; intClkSel = 1;
    pulseGo();
    waitLowAt(2);
    extLow = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 bitCnt frozen", int'(bitCnt), 3);
    chk("R7 internal high released", int'(sclDriveLow), 0);
    chk("R9 xferClk gated by line", int'(xferClk), 0);
    extLow = 1'b0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (sclDriveLow) break;
      @(negedge clk);
      cnt++;
      if (cnt == 3) chk("R9 xferClk high with line", int'(xferClk), 1);
    end
    chk("R7 resume count", cnt, 6);
    repeat (120) @(negedge clk);
    chk("R7 completes", int'(bitCnt), 9);

    // R8: no synchronization without internal source
    doReset();
    reloadVal = 8'd3; syncEn = 1; intClkSel = 0;
    pulseGo();
    waitLowAt(2);
    extLow = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 intClkSel=0 keeps counting", int'(bitCnt > 4'd5), 1);
    extLow = 1'b0;
    repeat (100) @(negedge clk);
    chk("R8 completes", int'(bitCnt), 9);

    doReset();
    reloadVal = 8'd3; syncEn = 0; intClkSel = 1;
    pulseGo();
    waitLowAt(2);
    extLow = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 syncEn=0 keeps counting", int'(bitCnt > 4'd5), 1);
    extLow = 1'b0;

    // R6: early fall reloads the low phase
    doReset();
    reloadVal = 8'd20; syncEn = 1; intClkSel = 1;
    pulseGo();
    repeat (5) @(negedge clk);
    extLow = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 cut to low", int'(sclDriveLow), 1);
    extLow = 1'b0;
    repeat (17) @(negedge clk);
    chk("R6 reloaded low still held", int'(sclDriveLow), 1);
    repeat (5) @(negedge clk);
    chk("R6 low ends after full period", int'(sclDriveLow), 0);

    doReset();
    reloadVal = 8'd20; syncEn = 0; intClkSel = 1;
    pulseGo();
    repeat (5) @(negedge clk);
    extLow = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no cut without sync", int'(sclDriveLow), 0);
    extLow = 1'b0;

    // R10: force low mid-transfer
    doReset();
    reloadVal = 8'd4;
    pulseGo();
    repeat (3) @(negedge clk);
    forceLow = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sclDriveLow) cnt++;
    end
    chk("R10 forced low cycles released", cnt, 0);
    forceLow = 1'b0;
    repeat (150) @(negedge clk);
    chk("R10 transfer completes", int'(bitCnt), 9);
    chk("R10 line released after", int'(sclDriveLow), 0);

    // R11: stop handling while parked
    doReset();
    reloadVal = 8'd3; hold9En = 1;
    pulseGo();
    repeat (120) @(negedge clk);
    chk("R4 parked low", int'(sclDriveLow), 1);
    stopSeen = 1'b1; relOnStop = 1'b0;
    @(negedge clk);
    stopSeen = 1'b0;
    @(negedge clk);
    chk("R11 stop ignored", int'(sclDriveLow), 1);
    stopSeen = 1'b1; relOnStop = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    chk("R11 stop releases", int'(sclDriveLow), 0);

    // R3 restart ignored, R11 stop mid-transfer
    doReset();
    reloadVal = 8'd3;
    pulseGo();
    for (int i = 0; i < 200; i++) begin
      if (bitCnt == 4'd4) break;
      @(negedge clk);
    end
    pulseGo();
    chk("R3 restart ignored", int'(bitCnt), 4);
    relOnStop = 1'b1; stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    chk("R11 stop mid-transfer", int'(sclDriveLow), 0);
    repeat (30) @(negedge clk);
    chk("R11 stays idle", int'(bitCnt), 4);
    chk("R11 line stays released", int'(sclDriveLow), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule